// File: doc/BRIEF.md
# Edge-Latched 4096 x 1 Static RAM

This block is a 4096-word by 1-bit static memory whose address is held inside the block, not by the bus master. An access opens when the active-high select `sel` rises. On that edge the block takes all twelve address bits into its own register. Address changes after that point have no effect until the next access opens. The cells form a 64 x 64 matrix. Six address bits choose the row and the other six choose the column. The row and column decoders work only while an access is open.

The data input passes through a latch. The latch follows `din` while `wen` is low and freezes on the clock edge where `wen` is high. A write stores that frozen bit at the latched location. A read loads the addressed bit into an output latch, and the latch keeps that bit after the access closes. The output is modelled as a data bit `dout` and a drive flag `dout_en`. When `dout_en` is low the pin is taken to be high impedance, so several of these blocks can share one data line.

All edges are found by sampling on `clk`. The block resets synchronously with `rst`, which is active high.

Top module: `edge_ram`

## Requirements
- R1: After reset, `dout` is 0 and `dout_en` is 0. The cell contents are undefined.
- R2: An access opens on a clock edge where `sel` is 1 and was 0 on the previous edge. The address is taken on that edge. Address values applied later in the same access have no effect.
- R3: The row is `{addr[8], addr[7], addr[6], addr[2], addr[1], addr[0]}`. The column is `{addr[11], addr[10], addr[9], addr[5], addr[4], addr[3]}`. Each of the 4096 addresses reaches its own cell. Addresses that differ in any one bit do not alias.
- R4: The input latch follows `din` on every edge where `wen` is 0 and holds on every edge where `wen` is 1. While the access is open, each edge with `sel`=1 and `wen`=1 writes the held bit into the latched cell. A change of `din` while `wen` is 1 is not stored.
- R5: On each edge after the opening edge that has `sel`=1 and `wen`=0, the latched cell is loaded into the output latch. The result shows on `dout` from that edge on.
- R6: `dout_en` is 1 only when `oe` is 1 and a read load has taken place in the access that is still open. It goes to 0 on the edge where `sel` is seen low.
- R7: `dout` keeps the last value loaded into the output latch. It does not change while the block is idle, and it does not change during a write access.
- R8: When no access is open, no cell changes, even if `wen` and `din` toggle. Stored data persists over any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock used to sample all controls |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Access select; a rise opens an access |
| wen | input | 1 | Write strobe; also freezes the input latch |
| addr | input | 12 | Word address, captured when an access opens |
| din | input | 1 | Write data |
| oe | input | 1 | Output buffer enable |
| dout | output | 1 | Output latch contents |
| dout_en | output | 1 | Drive flag; 0 means high impedance |

## Verification
The assertions assume that every control input changes only between clock edges and is never X after reset. They also assume that an access lasts at least two edges, so that the opening edge and a read or write edge are distinct. The bench drives every input on the falling clock edge. Each access task holds `sel` high for at least two rising edges and then lowers it for one or more edges. Within an access the bench changes `addr` and `din` on purpose, to show that those changes are ignored.

// File: rtl/edge_ram_pkg.sv
package edge_ram_pkg;
    localparam int ROW_BITS  = 6;
    localparam int COL_BITS  = 6;
    localparam int ADDR_BITS = ROW_BITS + COL_BITS;
    localparam int ROWS      = 1 << ROW_BITS;
    localparam int COLS      = 1 << COL_BITS;

    typedef logic [ROW_BITS-1:0]  row_t;
    typedef logic [COL_BITS-1:0]  col_t;
    typedef logic [ADDR_BITS-1:0] addr_t;

    typedef struct packed {
        row_t row;
        col_t col;
    } cell_loc_t;

    function automatic cell_loc_t split_addr(input addr_t a);
        cell_loc_t l;
        l.row = {a[8], a[7], a[6], a[2], a[1], a[0]};
        l.col = {a[11], a[10], a[9], a[5], a[4], a[3]};
        return l;
    endfunction
endpackage

// File: rtl/edge_ram_addr.sv
module edge_ram_addr
    import edge_ram_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel,
    input  logic      open_edge,
    input  logic      act,
    input  addr_t     addr,
    output cell_loc_t loc,
    output logic [ROWS-1:0] row_oh,
    output logic [COLS-1:0] col_oh
);
    addr_t a_q;

    always_ff @(posedge clk) begin
        if (rst)
            a_q <= '0;
        else if (open_edge)
            a_q <= addr;
    end

    assign loc = split_addr(a_q);

    // gated decoders: outputs are active only while an access is open
    always_comb begin
        row_oh = '0;
        col_oh = '0;
        if (act) begin
            row_oh[loc.row] = 1'b1;
            col_oh[loc.col] = 1'b1;
        end
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act && sel) |=> $stable(a_q));
    // R8
    dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !act |-> (row_oh == '0 && col_oh == '0));
endmodule

// File: rtl/edge_ram_matrix.sv
module edge_ram_matrix
    import edge_ram_pkg::*;
(
    input  logic            clk,
    input  logic            wr,
    input  logic [ROWS-1:0] row_oh,
    input  col_t            col,
    input  logic            wbit,
    output logic            rbit
);
    logic [ROWS-1:0] row_bits;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] line;
        always_ff @(posedge clk) begin
            if (wr && row_oh[r])
                line[col] <= wbit;
        end
        assign row_bits[r] = line[col];
    end

    assign rbit = |(row_bits & row_oh);
endmodule

// File: rtl/edge_ram_io.sv
module edge_ram_io (
    input  logic clk,
    input  logic rst,
    input  logic wen,
    input  logic din,
    input  logic rd_load,
    input  logic rd_end,
    input  logic cell_bit,
    input  logic oe,
    output logic wbit,
    output logic dout,
    output logic dout_en
);
    logic d_lat, q_lat, rd_done;

    // input latch: follows din while wen low, holds while wen high
    always_ff @(posedge clk) begin
        if (rst)
            d_lat <= 1'b0;
        else if (!wen)
            d_lat <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_lat   <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            if (rd_load)
                q_lat <= cell_bit;
            if (rd_end)
                rd_done <= 1'b0;
            else if (rd_load)
                rd_done <= 1'b1;
        end
    end

    assign wbit    = d_lat;
    assign dout    = q_lat;
    assign dout_en = oe & rd_done;

    // R4
    din_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        wen |=> $stable(d_lat));
    // R7
    qlat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_load |=> $stable(dout));
    // R6
    drive_end_chk: assert property (@(posedge clk) disable iff (rst)
        rd_end |=> !dout_en);
endmodule

// File: rtl/edge_ram.sv
module edge_ram
    import edge_ram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic                 wen,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic                 din,
    input  logic                 oe,
    output logic                 dout,
    output logic                 dout_en
);
    logic            act;
    logic            open_edge;
    logic            wr, rd_load;
    logic            wbit, cell_bit;
    cell_loc_t       loc;
    logic [ROWS-1:0] row_oh;
    logic [COLS-1:0] col_oh;

    always_ff @(posedge clk) begin
        if (rst)
            act <= 1'b0;
        else
            act <= sel;
    end

    assign open_edge = sel && !act;
    assign wr        = act && sel && wen;
    assign rd_load   = act && sel && !wen;

    edge_ram_addr u_addr (
        .clk(clk), .rst(rst), .sel(sel), .open_edge(open_edge), .act(act),
        .addr(addr), .loc(loc), .row_oh(row_oh), .col_oh(col_oh)
    );

    edge_ram_matrix u_mat (
        .clk(clk), .wr(wr), .row_oh(row_oh), .col(loc.col),
        .wbit(wbit), .rbit(cell_bit)
    );

    edge_ram_io u_io (
        .clk(clk), .rst(rst), .wen(wen), .din(din), .rd_load(rd_load),
        .rd_end(!sel), .cell_bit(cell_bit), .oe(oe), .wbit(wbit),
        .dout(dout), .dout_en(dout_en)
    );

    // R6
    drive_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (oe && act));
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dout_en && !dout));
    // R3
    col_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        act |-> $onehot0(col_oh) && (col_oh != '0));
endmodule

// File: tb/edge_ram_test.sv
module edge_ram_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        sel, wen, din, oe;
    logic [11:0] addr;
    logic        dout, dout_en;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    edge_ram uut (
        .clk(clk), .rst(rst), .sel(sel), .wen(wen), .addr(addr),
        .din(din), .oe(oe), .dout(dout), .dout_en(dout_en)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [11:0] a, input logic d);
        @(negedge clk); sel = 1; wen = 0; addr = a; din = d;
        @(negedge clk); wen = 1; din = ~d; addr = ~a;
        @(negedge clk); wen = 0; sel = 0;
        @(negedge clk);
    endtask

    task automatic read_word(input logic [11:0] a, output logic q, output logic en);
        @(negedge clk); sel = 1; wen = 0; addr = a;
        @(negedge clk); addr = ~a;
        @(negedge clk); q = dout; en = dout_en;
        sel = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 dout", dout, 1'b0);
        chk("R1 dout_en", dout_en, 1'b0);
    endtask

    task automatic t_basic();
        logic q, en;
        write_word(12'h123, 1'b1);
        read_word(12'h123, q, en);
        chk("R5 read data", q, 1'b1);
        chk("R6 drive during read", en, 1'b1);
        chk("R6 released after access", dout_en, 1'b0);
        chk("R7 dout held after access", dout, 1'b1);
        write_word(12'h123, 1'b0);
        read_word(12'h123, q, en);
        chk("R4 overwrite", q, 1'b0);
    endtask

    task automatic t_alias();
        logic q, en;
        write_word(12'h000, 1'b1);
        for (int b = 0; b < 12; b++) write_word(12'h001 << b, 1'b0);
        read_word(12'h000, q, en);
        chk("R3 base cell", q, 1'b1);
        for (int b = 0; b < 12; b++) begin
            read_word(12'h001 << b, q, en);
            chk("R3 single bit neighbour", q, 1'b0);
        end
        write_word(12'hFFF, 1'b1);
        read_word(12'hFFF, q, en);
        chk("R3 top cell", q, 1'b1);
    endtask

    task automatic t_addr_ignore();
        logic q, en;
        write_word(12'h5A5, 1'b1);
        write_word(12'hA5A, 1'b0);
        @(negedge clk); sel = 1; wen = 0; addr = 12'h5A5;
        @(negedge clk); addr = 12'hA5A;
        @(negedge clk); addr = 12'h000;
        chk("R2 address changes ignored", dout, 1'b1);
        sel = 0;
        @(negedge clk);
        read_word(12'hA5A, q, en);
        chk("R2 other cell intact", q, 1'b0);
    endtask

    task automatic t_oe();
        logic q, en;
        write_word(12'h0F0, 1'b1);
        oe = 0;
        read_word(12'h0F0, q, en);
        chk("R6 oe low gives high-Z", en, 1'b0);
        chk("R5 data loaded with oe low", q, 1'b1);
        oe = 1;
        @(negedge clk); sel = 1; wen = 0; addr = 12'h0F0;
        chk("R6 no drive before load", dout_en, 1'b0);
        @(negedge clk); chk("R6 not driving on opening edge", dout_en, 1'b0);
        @(negedge clk); chk("R6 drive after load", dout_en, 1'b1);
        sel = 0;
        @(negedge clk);
    endtask

    task automatic t_write_hold();
        logic q, en;
        read_word(12'h321, q, en);
        write_word(12'h321, 1'b0);
        read_word(12'h777, q, en);
        write_word(12'h777, ~q);
        chk("R7 dout unchanged by write", dout, q);
    endtask

    task automatic t_idle();
        logic q, en;
        write_word(12'h444, 1'b1);
        write_word(12'h445, 1'b0);
        addr = 12'h444;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); wen = i[0]; din = i[1];
        end
        wen = 0;
        read_word(12'h444, q, en);
        chk("R8 idle strobes ignored", q, 1'b1);
        read_word(12'h445, q, en);
        chk("R8 idle strobes ignored neighbour", q, 1'b0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; sel = 0; wen = 0; din = 0; oe = 1; addr = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_basic();
        t_alias();
        t_addr_ignore();
        t_oe();
        t_write_hold();
        t_idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule